// File: doc/BRIEF.md
# Serial Character Receiver

This block recovers asynchronous characters from one serial data line, least significant bit first. The line is sampled only on cycles where a sampling enable is high. That enable either runs at sixteen times the bit rate, in which case the block finds the middle of each bit itself, or at the bit rate, in which case every enable samples one bit. Static configuration inputs set the character length, the parity mode, the clock factor, and a compare character together with its event enable.

Each good character is placed in a one-entry holding register. The register raises a valid flag and keeps it until the consumer acknowledges. The held character carries its parity, framing and overrun flags. A line held at space for a whole character is reported as a break, with one pulse when the break starts and another when the line returns to mark. A character equal to the compare value produces a one-cycle match pulse if that event is enabled. In 16x mode a start bit that has gone back high by its middle sample is dropped.

Top module: `serial_char_rx`

## Requirements
- R1: The data length is 5 + `cfg_len`, covering 5 to 8 bits. The first data bit received lands in `rx_data[0]`, and the bits above the length read as zero.
- R2: `cfg_par` selects the parity mode: 0 none (no parity bit on the line), 1 even, 2 odd, 3 forced. In forced mode the parity bit must equal `cfg_pforce`. A mismatch sets `rx_perr` on that character.
- R3: With `cfg_x16`=1, the first enable that sees the line low counts as sample 1 of the start bit, and the start bit is confirmed at sample 8. Every later bit is sampled 16 enables after the previous sample. With `cfg_x16`=0, each enable samples one whole bit.
- R4: In 16x mode, a start bit that reads high at sample 8 is discarded: no character is delivered and the receiver goes back to looking for a start bit.
- R5: A stop bit sampled low sets `rx_ferr` on that character. The receiver then waits for the line to read high before it looks for another start bit.
- R6: When the data bits, the parity bit (if present) and the stop bit are all zero, the character is not delivered and `brk_start` pulses for one cycle. `brk_end` pulses for one cycle at the first enable that samples the line high afterwards, and not before.
- R7: When `cfg_cmp_ie`=1 and a delivered character equals `cfg_cmp`, `cmp_match` pulses for one cycle, in the same cycle that the character is loaded. When `cfg_cmp_ie`=0, or the character differs, there is no pulse.
- R8: A character that arrives while `rx_valid` is high and not being acknowledged replaces the held one and sets `rx_oerr`.
- R9: `rx_valid` rises two clock cycles after the clock edge whose enable samples the stop bit. It stays high until a cycle with `rx_ack` high, after which it is low, and `rx_oerr` clears with it.
- R10: After a synchronous reset, `rx_valid`, `rx_oerr`, `cmp_match`, `brk_start` and `brk_end` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| samp_en | input | 1 | Sampling enable (16x or 1x bit rate) |
| rxd | input | 1 | Serial data line, idle high |
| cfg_x16 | input | 1 | 1: sixteen enables per bit, 0: one enable per bit |
| cfg_len | input | 2 | Data length minus 5 |
| cfg_par | input | 2 | Parity mode: 0 none, 1 even, 2 odd, 3 forced |
| cfg_pforce | input | 1 | Expected parity bit value in forced mode |
| cfg_cmp | input | 8 | Compare character |
| cfg_cmp_ie | input | 1 | Enables the compare-match pulse |
| rx_ack | input | 1 | Consumer takes the held character |
| rx_valid | output | 1 | Holding register holds a character |
| rx_data | output | 8 | Held character |
| rx_perr | output | 1 | Parity error of the held character |
| rx_ferr | output | 1 | Framing error of the held character |
| rx_oerr | output | 1 | Held character overwrote an unread one |
| brk_start | output | 1 | One-cycle pulse: break detected |
| brk_end | output | 1 | One-cycle pulse: line back to mark after a break |
| cmp_match | output | 1 | One-cycle pulse: compare match |

## Verification
The break pulse is due one cycle after the edge that samples the stop bit, and a held character with its match pulse is due two cycles after that edge. In 1x mode the bench samples `rx_valid` on the falling edge straight after the stop-bit enable, expecting low, and again one cycle later, expecting high. Every other check waits until at least two further bit times have passed, so the result is settled when it is read. Pulses are counted on falling edges, and each check compares the count before and after a stimulus. This also shows that `brk_end` stays silent while the line is still low.

// File: rtl/scr_pkg.sv
// Shared types and codes for the serial character receiver.
// Assumes nothing beyond IEEE 1800-2017.
package scr_pkg;
    // Parity mode codes presented on cfg_par
    localparam logic [1:0] PAR_NONE  = 2'd0;
    localparam logic [1:0] PAR_EVEN  = 2'd1;
    localparam logic [1:0] PAR_ODD   = 2'd2;
    localparam logic [1:0] PAR_FORCE = 2'd3;

    // Framer states
    typedef enum logic [2:0] {
        S_HUNT, S_START, S_DATA, S_PAR, S_STOP, S_MARK
    } rx_state_t;
endpackage

// File: rtl/scr_framer.sv
// Bit timing and character assembly. It finds the start bit, samples the
// data, parity and stop bits, and flags parity, framing and break.
// Assumes OVS is a power of two and the cfg_* inputs change only while idle.
module scr_framer #(
    parameter int DATA_W  = 8,
    parameter int OVS     = 16,
    parameter int MIN_LEN = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              samp_en,
    input  logic              rxd,
    input  logic              cfg_x16,
    input  logic [1:0]        cfg_len,
    input  logic [1:0]        cfg_par,
    input  logic              cfg_pforce,
    output logic              fr_done,
    output logic [DATA_W-1:0] fr_data,
    output logic              fr_perr,
    output logic              fr_ferr,
    output logic              brk_start,
    output logic              brk_end
);
    import scr_pkg::*;

    localparam int PH_W = $clog2(OVS);
    localparam int BI_W = $clog2(DATA_W);
    localparam int MID  = OVS / 2;

    rx_state_t         state;
    logic [PH_W-1:0]   ph;
    logic [BI_W-1:0]   bi;
    logic [DATA_W-1:0] sh;
    logic              pbit;
    logic              brk_act;
    logic              take;
    logic              last_bit;
    logic              perr_calc;
    logic              is_brk;
    logic [DATA_W-1:0] len_mask;

    // Marks the enable that falls at a bit centre
    always_comb take = samp_en && (!cfg_x16 || ph == PH_W'(OVS - 1));

    // Marks the final data bit for the configured length
    always_comb last_bit = (bi == BI_W'(MIN_LEN - 1) + BI_W'(cfg_len));

    // Checks the received parity bit against the selected mode
    always_comb begin
        case (cfg_par)
            PAR_EVEN:  perr_calc = (^sh) ^ pbit;
            PAR_ODD:   perr_calc = ~((^sh) ^ pbit);
            PAR_FORCE: perr_calc = (pbit != cfg_pforce);
            default:   perr_calc = 1'b0;
        endcase
    end

    // Recognises a character made of zeros only, stop bit included
    always_comb is_brk = (sh == '0) && !rxd && ((cfg_par == PAR_NONE) || !pbit);

    // Bits that the configured length may use
    always_comb len_mask = DATA_W'((1 << (MIN_LEN + int'(cfg_len))) - 1);

    // Receive state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_HUNT;
            ph        <= '0;
            bi        <= '0;
            sh        <= '0;
            pbit      <= 1'b0;
            brk_act   <= 1'b0;
            fr_done   <= 1'b0;
            fr_data   <= '0;
            fr_perr   <= 1'b0;
            fr_ferr   <= 1'b0;
            brk_start <= 1'b0;
            brk_end   <= 1'b0;
        end else begin
            fr_done   <= 1'b0;
            brk_start <= 1'b0;
            brk_end   <= 1'b0;
            case (state)
                S_HUNT: if (samp_en && !rxd) begin
                    sh   <= '0;
                    bi   <= '0;
                    pbit <= 1'b0;
                    ph   <= PH_W'(1);
                    state <= cfg_x16 ? S_START : S_DATA;
                end
                S_START: if (samp_en) begin
                    if (ph == PH_W'(MID - 1)) begin
                        ph    <= '0;
                        state <= rxd ? S_HUNT : S_DATA;
                    end else begin
                        ph <= ph + PH_W'(1);
                    end
                end
                S_DATA: if (samp_en) begin
                    ph <= ph + PH_W'(1);
                    if (take) begin
                        sh[bi] <= rxd;
                        bi     <= bi + BI_W'(1);
                        if (last_bit) state <= (cfg_par == PAR_NONE) ? S_STOP : S_PAR;
                    end
                end
                S_PAR: if (samp_en) begin
                    ph <= ph + PH_W'(1);
                    if (take) begin
                        pbit  <= rxd;
                        state <= S_STOP;
                    end
                end
                S_STOP: if (samp_en) begin
                    ph <= ph + PH_W'(1);
                    if (take) begin
                        fr_done   <= !is_brk;
                        fr_data   <= sh;
                        fr_perr   <= perr_calc;
                        fr_ferr   <= !rxd;
                        brk_start <= is_brk;
                        brk_act   <= is_brk;
                        state     <= rxd ? S_HUNT : S_MARK;
                    end
                end
                S_MARK: if (samp_en && rxd) begin
                    brk_end <= brk_act;
                    brk_act <= 1'b0;
                    state   <= S_HUNT;
                end
                default: state <= S_HUNT;
            endcase
        end
    end

    AST_BRK_NO_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
        brk_start |-> !fr_done) else $error("break delivered a character"); // R6
    AST_BRK_END_NEEDS_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        brk_end |-> $past(rxd) && $past(samp_en)) else $error("break end without mark"); // R6
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        fr_done |-> (fr_data & ~len_mask) == '0) else $error("bits above length set"); // R1
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fr_done |=> !fr_done) else $error("done longer than a cycle"); // R9
    AST_FERR_LOW_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_done && fr_ferr) |-> !$past(rxd)) else $error("framing flag with high stop"); // R5
endmodule

// File: rtl/scr_holdreg.sv
// One-entry holding register with a valid/acknowledge handshake.
// It flags overrun and raises the compare-match pulse.
// Assumes fr_done is a one-cycle pulse.
module scr_holdreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fr_done,
    input  logic [DATA_W-1:0] fr_data,
    input  logic              fr_perr,
    input  logic              fr_ferr,
    input  logic              rx_ack,
    input  logic [DATA_W-1:0] cfg_cmp,
    input  logic              cfg_cmp_ie,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_perr,
    output logic              rx_ferr,
    output logic              rx_oerr,
    output logic              cmp_match
);
    // Loads new characters and clears on acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_valid  <= 1'b0;
            rx_data   <= '0;
            rx_perr   <= 1'b0;
            rx_ferr   <= 1'b0;
            rx_oerr   <= 1'b0;
            cmp_match <= 1'b0;
        end else begin
            cmp_match <= 1'b0;
            if (fr_done) begin
                rx_valid  <= 1'b1;
                rx_data   <= fr_data;
                rx_perr   <= fr_perr;
                rx_ferr   <= fr_ferr;
                rx_oerr   <= rx_valid && !rx_ack;
                cmp_match <= cfg_cmp_ie && (fr_data == cfg_cmp);
            end else if (rx_ack) begin
                rx_valid <= 1'b0;
                rx_oerr  <= 1'b0;
            end
        end
    end

    AST_OERR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        rx_oerr |-> rx_valid) else $error("overrun without held data"); // R8
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ack && !fr_done) |=> !rx_valid) else $error("ack ignored"); // R9
    AST_MATCH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_match |-> rx_valid && rx_data == $past(cfg_cmp) && $past(cfg_cmp_ie))
        else $error("match on wrong data"); // R7
endmodule

// File: rtl/serial_char_rx.sv
// Top of the serial character receiver: the framer feeds the holding register.
// Assumes samp_en is synchronous to clk and the configuration is static while
// a character is on the line.
module serial_char_rx #(
    parameter int DATA_W  = 8,
    parameter int OVS     = 16,
    parameter int MIN_LEN = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              samp_en,
    input  logic              rxd,
    input  logic              cfg_x16,
    input  logic [1:0]        cfg_len,
    input  logic [1:0]        cfg_par,
    input  logic              cfg_pforce,
    input  logic [DATA_W-1:0] cfg_cmp,
    input  logic              cfg_cmp_ie,
    input  logic              rx_ack,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_perr,
    output logic              rx_ferr,
    output logic              rx_oerr,
    output logic              brk_start,
    output logic              brk_end,
    output logic              cmp_match
);
    logic              fr_done;
    logic [DATA_W-1:0] fr_data;
    logic              fr_perr;
    logic              fr_ferr;

    scr_framer #(.DATA_W(DATA_W), .OVS(OVS), .MIN_LEN(MIN_LEN)) u_framer (
        .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .rxd(rxd),
        .cfg_x16(cfg_x16), .cfg_len(cfg_len), .cfg_par(cfg_par),
        .cfg_pforce(cfg_pforce), .fr_done(fr_done), .fr_data(fr_data),
        .fr_perr(fr_perr), .fr_ferr(fr_ferr), .brk_start(brk_start),
        .brk_end(brk_end)
    );

    scr_holdreg #(.DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .fr_done(fr_done), .fr_data(fr_data),
        .fr_perr(fr_perr), .fr_ferr(fr_ferr), .rx_ack(rx_ack),
        .cfg_cmp(cfg_cmp), .cfg_cmp_ie(cfg_cmp_ie), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_perr(rx_perr), .rx_ferr(rx_ferr),
        .rx_oerr(rx_oerr), .cmp_match(cmp_match)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !$past(rst_n) |-> !rx_valid && !brk_start && !brk_end && !cmp_match)
        else $error("outputs active after reset"); // R10
endmodule

// File: tb/serial_char_rx_bench.sv
// Self-checking bench: sweeps length, parity mode, clock factor and data, then
// covers the error, break, compare and overrun cases.
module serial_char_rx_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       samp_en = 1'b0;
    logic       rxd = 1'b1;
    logic       cfg_x16 = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic [1:0] cfg_par = 2'd0;
    logic       cfg_pforce = 1'b1;
    logic [7:0] cfg_cmp = 8'h00;
    logic       cfg_cmp_ie = 1'b0;
    logic       rx_ack = 1'b0;
    logic       rx_valid, rx_perr, rx_ferr, rx_oerr, brk_start, brk_end, cmp_match;
    logic [7:0] rx_data;

    int n_chk = 0, n_fail = 0;
    int n_bs = 0, n_be = 0, n_cm = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    serial_char_rx u_serial_char_rx (
        .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .rxd(rxd),
        .cfg_x16(cfg_x16), .cfg_len(cfg_len), .cfg_par(cfg_par),
        .cfg_pforce(cfg_pforce), .cfg_cmp(cfg_cmp), .cfg_cmp_ie(cfg_cmp_ie),
        .rx_ack(rx_ack), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_oerr(rx_oerr),
        .brk_start(brk_start), .brk_end(brk_end), .cmp_match(cmp_match)
    );

    // Pulse counters, sampled away from the active edge
    always @(negedge clk) begin
        if (brk_start) n_bs++;
        if (brk_end)   n_be++;
        if (cmp_match) n_cm++;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input logic v);
        @(negedge clk); rxd = v; samp_en = 1'b1;
        @(negedge clk); samp_en = 1'b0;
    endtask

    task automatic send_bit(input logic v);
        repeat (cfg_x16 ? 16 : 1) tick(v);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic pb, input logic stopb);
        send_bit(1'b0);
        for (int i = 0; i < 5 + int'(cfg_len); i++) send_bit(d[i]);
        if (cfg_par != 2'd0) send_bit(pb);
        send_bit(stopb);
    endtask

    task automatic idle(input int n);
        repeat (n) send_bit(1'b1);
    endtask

    task automatic ack();
        @(negedge clk); rx_ack = 1'b1;
        @(negedge clk); rx_ack = 1'b0;
    endtask

    function automatic logic [7:0] mask_of(input logic [1:0] l);
        return 8'hFF >> (3 - int'(l));
    endfunction

    function automatic logic good_par(input logic [7:0] d);
        logic p;
        p = ^(d & mask_of(cfg_len));
        case (cfg_par)
            2'd1:    return p;
            2'd2:    return ~p;
            2'd3:    return cfg_pforce;
            default: return 1'b0;
        endcase
    endfunction

    // {valid, perr, ferr, oerr, data}
    function automatic logic [31:0] packed_out();
        return {20'd0, rx_valid, rx_perr, rx_ferr, rx_oerr, rx_data};
    endfunction

    function automatic logic [31:0] exp_out(input logic [7:0] d, input logic pe, input logic fe, input logic oe);
        return {20'd0, 1'b1, pe, fe, oe, d};
    endfunction

    initial begin
        logic [7:0] pats [4];
        int bs0, be0, cm0;
        pats[0] = 8'hA5; pats[1] = 8'hFF; pats[2] = 8'h3C; pats[3] = 8'h69;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk("R10 reset outputs", {27'd0, rx_valid, rx_oerr, cmp_match, brk_start, brk_end}, 32'd0);

        // R1 R2 R3: sweep clock factor, length, parity mode, data
        for (int x = 1; x >= 0; x--) begin
            for (int l = 0; l < 4; l++) begin
                for (int p = 0; p < 4; p++) begin
                    for (int k = 0; k < 4; k++) begin
                        cfg_x16 = x[0]; cfg_len = l[1:0]; cfg_par = p[1:0];
                        send_frame(pats[k], good_par(pats[k]), 1'b1);
                        idle(2);
                        chk($sformatf("R1/R2/R3 sweep x16=%0d len=%0d par=%0d", x, l + 5, p),
                            packed_out(), exp_out(pats[k] & mask_of(cfg_len), 1'b0, 1'b0, 1'b0));
                        ack();
                    end
                end
            end
        end

        // R2: wrong parity in even, odd and forced modes
        cfg_x16 = 1'b1; cfg_len = 2'd3;
        for (int p = 1; p < 4; p++) begin
            cfg_par = p[1:0];
            send_frame(8'h5B, ~good_par(8'h5B), 1'b1);
            idle(2);
            chk($sformatf("R2 parity error mode %0d", p), packed_out(), exp_out(8'h5B, 1'b1, 1'b0, 1'b0));
            ack();
        end

        // R9: latency and acknowledge, 1x mode
        cfg_x16 = 1'b0; cfg_par = 2'd0;
        send_frame(8'hC3, 1'b0, 1'b1);
        chk("R9 valid not yet one cycle after stop edge", {31'd0, rx_valid}, 32'd0);
        @(negedge clk);
        chk("R9 valid two cycles after stop edge", packed_out(), exp_out(8'hC3, 1'b0, 1'b0, 1'b0));
        ack();
        chk("R9 valid cleared by ack", {31'd0, rx_valid}, 32'd0);

        // R4: false start in 16x mode, then a good character
        cfg_x16 = 1'b1;
        repeat (5) tick(1'b0);
        idle(3);
        chk("R4 false start delivers nothing", {31'd0, rx_valid}, 32'd0);
        send_frame(8'h5A, 1'b0, 1'b1);
        idle(2);
        chk("R4 receiver hunts again after false start", packed_out(), exp_out(8'h5A, 1'b0, 1'b0, 1'b0));
        ack();

        // R5: framing error, then recovery
        send_frame(8'h3C, 1'b0, 1'b0);
        send_bit(1'b0);
        idle(2);
        chk("R5 framing error flagged", packed_out(), exp_out(8'h3C, 1'b0, 1'b1, 1'b0));
        ack();
        send_frame(8'h81, 1'b0, 1'b1);
        idle(2);
        chk("R5 clean character after framing error", packed_out(), exp_out(8'h81, 1'b0, 1'b0, 1'b0));
        ack();

        // R6: break start and end, with even parity
        cfg_par = 2'd1;
        bs0 = n_bs; be0 = n_be;
        send_frame(8'h00, 1'b0, 1'b0);
        send_bit(1'b0); send_bit(1'b0);
        chk("R6 break start pulse", n_bs - bs0, 1);
        chk("R6 no break end while line low", n_be - be0, 0);
        chk("R6 break delivers no character", {31'd0, rx_valid}, 32'd0);
        idle(2);
        chk("R6 break end pulse on mark", n_be - be0, 1);
        cfg_par = 2'd0;

        // R8: overrun
        send_frame(8'h11, 1'b0, 1'b1);
        idle(1);
        send_frame(8'h22, 1'b0, 1'b1);
        idle(2);
        chk("R8 overrun flagged, newest kept", packed_out(), exp_out(8'h22, 1'b0, 1'b0, 1'b1));
        ack();
        chk("R8 overrun cleared with ack", {30'd0, rx_valid, rx_oerr}, 32'd0);

        // R7: compare match
        cfg_cmp = 8'h35; cfg_cmp_ie = 1'b1;
        cm0 = n_cm;
        send_frame(8'h35, 1'b0, 1'b1); idle(2); ack();
        chk("R7 match pulse on equal", n_cm - cm0, 1);
        send_frame(8'h36, 1'b0, 1'b1); idle(2); ack();
        chk("R7 no pulse on different", n_cm - cm0, 1);
        cfg_cmp_ie = 1'b0;
        send_frame(8'h35, 1'b0, 1'b1); idle(2); ack();
        chk("R7 no pulse when disabled", n_cm - cm0, 1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (180000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule